// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block takes configuration writes from a host over a slow three-wire link: a serial clock, a serial data line and an active-low enable. While the enable is low, each rising edge of the serial clock shifts one data bit into a frame register. When the enable returns high, the last 22 bits shifted form the word. The upper 18 bits are the payload and the lower 4 bits select a target register. The payload is written into that register, and a one-cycle strobe marks the write.

The three serial lines are brought into the system clock domain through two-flop synchronizers. Edges are detected on the synchronized levels, so the system clock must run at least four times faster than the serial clock. The port holds five registers: a main configuration word, a pair of power enables, and three divider values of 18, 17 and 16 bits. Their decoded fields are driven to the rest of the chip. Frames may be longer than 22 bits. Writes always land, whatever the power enables say.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is read as a 22-bit word in shift order. The first bit shifted of the final 22 is payload bit 17, and the last bit shifted is address bit 0. The payload occupies word bits 21:4 and the address occupies word bits 3:0.
- R2: A bit is taken only on a rising edge of `ser_clk` while `ser_en_n` is low. The bit taken is the value of `ser_dat` at that edge.
- R3: The frame is committed when `ser_en_n` rises, and the registers change 3 system clocks after the rise is first sampled. While `ser_en_n` is high, activity on `ser_clk` and `ser_dat` leaves the frame register untouched, so a frame with no clock pulses re-commits the previous word.
- R4: Bits shifted before the final 22 of a frame have no effect.
- R5: Address 0 writes the main configuration word, and address 2 writes the power enables. Address 3 loads `n_rf1` from payload bits 17:0. Address 4 loads `n_rf2` from payload bits 16:0. Address 5 loads `n_if` from payload bits 15:0.
- R6: `cfg_word` shows the whole stored main configuration payload. `aux_sel` is payload bits 13:12, `low_pwr` is payload bit 5 and `auto_pd` is payload bit 3.
- R7: For the power enables register, `if_on` is payload bit 1 and `rf_on` is payload bit 0.
- R8: A write to address 1 or to any address from 6 to 15 changes no output and raises no strobe.
- R9: `wr_stb` is one-hot for a valid write and is high for exactly one cycle, in the cycle the register shows its new value. The bits map as follows: bit 0 is main configuration, bit 1 is power enables, bit 2 is `n_rf1`, bit 3 is `n_rf2` and bit 4 is `n_if`.
- R10: After reset, every register is zero except `cfg_word`, which is 18'h00002 (bit 1 set), and no strobe is high.
- R11: Writes land even when both power enables and `auto_pd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data from the host |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| cfg_word | output | 18 | Stored main configuration payload |
| aux_sel | output | 2 | Auxiliary output select field |
| low_pwr | output | 1 | Low-power flag for the IF output stage |
| auto_pd | output | 1 | Auto power-up flag |
| if_on | output | 1 | IF synthesizer enable |
| rf_on | output | 1 | RF synthesizer enable |
| n_rf1 | output | 18 | First RF divider value |
| n_rf2 | output | 17 | Second RF divider value |
| n_if | output | 16 | IF divider value |
| wr_stb | output | 5 | One-cycle write strobe per register |

## Verification
The bench sends a 30-bit frame whose leading junk would change the divider value if the port counted bits from the start, rather than keeping the last 22. It toggles the clock and data lines of the serial link while enable is high, then sends an empty enable pulse. A port that shifted while disabled would commit an all-ones address and miss the expected re-commit strobe. Writes to reserved addresses and to payload bits above each divider's width show a decoder that aliases addresses or keeps reserved bits. Frames sent with every power enable cleared show a port that gates its own writes on power state.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;
    localparam int DATA_W      = 18;
    localparam int ADDR_W      = 4;
    localparam int FRAME_W     = DATA_W + ADDR_W;
    localparam int SYNC_STAGES = 2;
    localparam int NRF1_W      = 18;
    localparam int NRF2_W      = 17;
    localparam int NIF_W       = 16;
    localparam int NUM_REGS    = 5;

    // field positions inside the payload
    localparam int AUX_LSB  = 12;
    localparam int LPWR_BIT = 5;
    localparam int APD_BIT  = 3;
    localparam int IFEN_BIT = 1;
    localparam int RFEN_BIT = 0;

    // strobe bit per register
    localparam int STB_MAIN = 0;
    localparam int STB_PWR  = 1;
    localparam int STB_RF1  = 2;
    localparam int STB_RF2  = 3;
    localparam int STB_IF   = 4;

    localparam logic [DATA_W-1:0] MAIN_RST = DATA_W'(2);

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MAIN = 4'd0,
        ADDR_PWR  = 4'd2,
        ADDR_RF1  = 4'd3,
        ADDR_RF2  = 4'd4,
        ADDR_IF   = 4'd5
    } reg_addr_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } frame_t;

    typedef struct packed {
        logic [1:0] aux_sel;
        logic       low_pwr;
        logic       auto_pd;
    } main_fields_t;

    function automatic main_fields_t decode_main(input logic [DATA_W-1:0] w);
        main_fields_t f;
        f.aux_sel = w[AUX_LSB +: 2];
        f.low_pwr = w[LPWR_BIT];
        f.auto_pd = w[APD_BIT];
        return f;
    endfunction

    function automatic logic [NUM_REGS-1:0] addr_to_sel(input logic [ADDR_W-1:0] a);
        logic [NUM_REGS-1:0] s;
        s = '0;
        case (a)
            ADDR_MAIN: s[STB_MAIN] = 1'b1;
            ADDR_PWR:  s[STB_PWR]  = 1'b1;
            ADDR_RF1:  s[STB_RF1]  = 1'b1;
            ADDR_RF2:  s[STB_RF2]  = 1'b1;
            ADDR_IF:   s[STB_IF]   = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/scp_sync.sv
`timescale 1ns/1ps
module scp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
`timescale 1ns/1ps
module scp_shifter
    import scp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  logic   bit_in,
    output frame_t frame_q
);
    logic [FRAME_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)       sreg <= '0;
        else if (take) sreg <= {sreg[FRAME_W-2:0], bit_in};
    end

    assign frame_q = frame_t'(sreg);
endmodule

// File: rtl/scp_reg_bank.sv
`timescale 1ns/1ps
module scp_reg_bank
    import scp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  frame_t              frame,
    output logic [DATA_W-1:0]   cfg_q,
    output logic [1:0]          pwr_q,
    output logic [NRF1_W-1:0]   rf1_q,
    output logic [NRF2_W-1:0]   rf2_q,
    output logic [NIF_W-1:0]    if_q,
    output logic [NUM_REGS-1:0] stb_q
);
    logic [NUM_REGS-1:0] sel;

    assign sel = commit ? addr_to_sel(frame.addr) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= MAIN_RST;
            pwr_q <= '0;
            rf1_q <= '0;
            rf2_q <= '0;
            if_q  <= '0;
            stb_q <= '0;
        end else begin
            stb_q <= sel;
            if (sel[STB_MAIN]) cfg_q <= frame.data;
            if (sel[STB_PWR])  pwr_q <= {frame.data[IFEN_BIT], frame.data[RFEN_BIT]};
            if (sel[STB_RF1])  rf1_q <= frame.data[NRF1_W-1:0];
            if (sel[STB_RF2])  rf2_q <= frame.data[NRF2_W-1:0];
            if (sel[STB_IF])   if_q  <= frame.data[NIF_W-1:0];
        end
    end
endmodule

// File: rtl/serial_cfg_port.sv
`timescale 1ns/1ps
module serial_cfg_port
    import scp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk,
    input  logic                ser_dat,
    input  logic                ser_en_n,
    output logic [DATA_W-1:0]   cfg_word,
    output logic [1:0]          aux_sel,
    output logic                low_pwr,
    output logic                auto_pd,
    output logic                if_on,
    output logic                rf_on,
    output logic [NRF1_W-1:0]   n_rf1,
    output logic [NRF2_W-1:0]   n_rf2,
    output logic [NIF_W-1:0]    n_if,
    output logic [NUM_REGS-1:0] wr_stb
);
    localparam int IN_W    = 3;
    localparam int IDX_DAT = 0;
    localparam int IDX_CK  = 1;
    localparam int IDX_EN  = 2;
    localparam logic [IN_W-1:0] IDLE = 3'b100;   // enable high, clock and data low

    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] sync_lvl;
    logic            ck_prev, en_prev;
    logic            en_lvl, en_rise, bit_take;
    frame_t          frame_q;
    logic [1:0]      pwr_q;
    main_fields_t    mf;

    assign raw_in = {ser_en_n, ser_clk, ser_dat};

    for (genvar g = 0; g < IN_W; g++) begin : g_sync
        scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE[g])) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_in[g]),
            .q   (sync_lvl[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_prev <= IDLE[IDX_CK];
            en_prev <= IDLE[IDX_EN];
        end else begin
            ck_prev <= sync_lvl[IDX_CK];
            en_prev <= sync_lvl[IDX_EN];
        end
    end

    assign en_lvl   = sync_lvl[IDX_EN];
    assign en_rise  = en_lvl & ~en_prev;
    assign bit_take = ~en_lvl & sync_lvl[IDX_CK] & ~ck_prev;

    scp_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .take    (bit_take),
        .bit_in  (sync_lvl[IDX_DAT]),
        .frame_q (frame_q)
    );

    scp_reg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .commit (en_rise),
        .frame  (frame_q),
        .cfg_q  (cfg_word),
        .pwr_q  (pwr_q),
        .rf1_q  (n_rf1),
        .rf2_q  (n_rf2),
        .if_q   (n_if),
        .stb_q  (wr_stb)
    );

    assign mf      = decode_main(cfg_word);
    assign aux_sel = mf.aux_sel;
    assign low_pwr = mf.low_pwr;
    assign auto_pd = mf.auto_pd;
    assign if_on   = pwr_q[1];
    assign rf_on   = pwr_q[0];
endmodule

// File: rtl/scp_checker.sv
`timescale 1ns/1ps
module scp_checker
    import scp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                en_lvl,
    input logic                en_rise,
    input frame_t              frame_q,
    input logic [DATA_W-1:0]   cfg_word,
    input logic                if_on,
    input logic                rf_on,
    input logic [NRF1_W-1:0]   n_rf1,
    input logic [NRF2_W-1:0]   n_rf2,
    input logic [NIF_W-1:0]    n_if,
    input logic [NUM_REGS-1:0] wr_stb
);
    assert_stb_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

    assert_stb_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb != '0) |=> (wr_stb == '0));

    assert_commit_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb != '0) |-> $past(en_rise));

    assert_no_shift_idle_R2: assert property (@(posedge clk) disable iff (rst)
        en_lvl |=> $stable(frame_q));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[STB_MAIN] |-> $stable(cfg_word));

    assert_pwr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[STB_PWR] |-> ($stable(if_on) && $stable(rf_on)));

    assert_rf1_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[STB_RF1] |-> $stable(n_rf1));

    assert_rf2_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[STB_RF2] |-> $stable(n_rf2));

    assert_if_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[STB_IF] |-> $stable(n_if));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (cfg_word == MAIN_RST && n_rf1 == '0 && n_rf2 == '0 &&
                 n_if == '0 && !if_on && !rf_on && wr_stb == '0));
endmodule

bind serial_cfg_port scp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_lvl   (en_lvl),
    .en_rise  (en_rise),
    .frame_q  (frame_q),
    .cfg_word (cfg_word),
    .if_on    (if_on),
    .rf_on    (rf_on),
    .n_rf1    (n_rf1),
    .n_rf2    (n_rf2),
    .n_if     (n_if),
    .wr_stb   (wr_stb)
);

// File: tb/tb_serial_cfg_port.sv
`timescale 1ns/1ps
module tb_serial_cfg_port;
    import scp_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
    logic [17:0] cfg_word;
    logic [1:0]  aux_sel;
    logic        low_pwr, auto_pd, if_on, rf_on;
    logic [17:0] n_rf1;
    logic [16:0] n_rf2;
    logic [15:0] n_if;
    logic [4:0]  wr_stb;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_cfg_port dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
        .cfg_word(cfg_word), .aux_sel(aux_sel), .low_pwr(low_pwr), .auto_pd(auto_pd),
        .if_on(if_on), .rf_on(rf_on), .n_rf1(n_rf1), .n_rf2(n_rf2), .n_if(n_if),
        .wr_stb(wr_stb)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [17:0] m_cfg;
    logic [1:0]  m_pd;
    logic [17:0] m_rf1;
    logic [16:0] m_rf2;
    logic [15:0] m_if;
    logic [4:0]  m_stb;
    bit          bitq[$];
    bit          h_en[3], h_ck[3], h_dt[3];   // index 0 = newest past sample

    task automatic model_commit();
        logic [21:0] w;
        logic [17:0] d;
        logic [3:0]  a;
        w = '0;
        foreach (bitq[i]) w = {w[20:0], bitq[i]};
        d = w[21:4];
        a = w[3:0];
        case (a)
            4'd0: begin m_cfg = d;           m_stb = 5'b00001; end
            4'd2: begin m_pd  = {d[1], d[0]}; m_stb = 5'b00010; end
            4'd3: begin m_rf1 = d;           m_stb = 5'b00100; end
            4'd4: begin m_rf2 = d[16:0];     m_stb = 5'b01000; end
            4'd5: begin m_if  = d[15:0];     m_stb = 5'b10000; end
            default: m_stb = '0;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 18'h00002; m_pd = '0; m_rf1 = '0; m_rf2 = '0; m_if = '0; m_stb = '0;
            bitq.delete();
            for (int i = 0; i < 22; i++) bitq.push_back(1'b0);
            for (int i = 0; i < 3; i++) begin h_en[i] = 1'b1; h_ck[i] = 1'b0; h_dt[i] = 1'b0; end
        end else begin
            m_stb = '0;
            if (!h_en[1] && h_ck[1] && !h_ck[2]) begin
                bitq.push_back(h_dt[1]);
                if (bitq.size() > 22) void'(bitq.pop_front());
            end
            if (h_en[1] && !h_en[2]) model_commit();
            for (int i = 2; i > 0; i--) begin
                h_en[i] = h_en[i-1]; h_ck[i] = h_ck[i-1]; h_dt[i] = h_dt[i-1];
            end
            h_en[0] = ser_en_n; h_ck[0] = ser_clk; h_dt[0] = ser_dat;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cfg_word == m_cfg, "R6 cfg_word", 32'(cfg_word), 32'(m_cfg));
            chk({aux_sel, low_pwr, auto_pd} == {m_cfg[13:12], m_cfg[5], m_cfg[3]},
                "R6 decoded fields", 32'({aux_sel, low_pwr, auto_pd}),
                32'({m_cfg[13:12], m_cfg[5], m_cfg[3]}));
            chk({if_on, rf_on} == m_pd, "R7 power enables", 32'({if_on, rf_on}), 32'(m_pd));
            chk(n_rf1 == m_rf1, "R5 n_rf1", 32'(n_rf1), 32'(m_rf1));
            chk(n_rf2 == m_rf2, "R5 n_rf2", 32'(n_rf2), 32'(m_rf2));
            chk(n_if == m_if, "R5 n_if", 32'(n_if), 32'(m_if));
            chk(wr_stb == m_stb, "R9 wr_stb", 32'(wr_stb), 32'(m_stb));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int nbits, input logic [63:0] bits);
        ser_en_n = 1'b0;
        tick(2);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            ser_clk = 1'b0;
            tick(4);
            ser_clk = 1'b1;
            tick(4);
        end
        ser_clk = 1'b0;
        tick(2);
        ser_en_n = 1'b1;
        tick(8);
    endtask

    task automatic wr(input logic [3:0] addr, input logic [17:0] data);
        send_frame(22, 64'({data, addr}));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        bit saw;
        logic [3:0] alist [7];
        alist = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd1, 4'd7};
        tick(4);
        rst = 1'b0;
        tick(2);
        // R10 reset state
        chk(cfg_word == 18'h00002, "R10 cfg_word reset", 32'(cfg_word), 32'h2);
        chk(n_rf1 == 0 && n_rf2 == 0 && n_if == 0, "R10 dividers reset", 32'(n_rf1), 32'h0);
        chk(!if_on && !rf_on && wr_stb == 0, "R10 enables/strobe reset", 32'({if_on, rf_on, wr_stb}), 32'h0);

        wr(4'd0, 18'h03028);
        chk(aux_sel == 2'd3 && low_pwr && auto_pd, "R6 main fields", 32'({aux_sel, low_pwr, auto_pd}), 32'hF);
        wr(4'd2, 18'h00002);
        chk(if_on && !rf_on, "R7 if only", 32'({if_on, rf_on}), 32'h2);
        wr(4'd3, 18'h2ABCD);
        chk(n_rf1 == 18'h2ABCD, "R1 R5 n_rf1 order", 32'(n_rf1), 32'h2ABCD);
        wr(4'd4, 18'h3FFFF);
        chk(n_rf2 == 17'h1FFFF, "R5 n_rf2 width", 32'(n_rf2), 32'h1FFFF);
        wr(4'd5, 18'h31234);
        chk(n_if == 16'h1234, "R5 n_if width", 32'(n_if), 32'h1234);

        // R4: eight leading junk bits
        send_frame(30, 64'({8'hA5, 18'h00155, 4'd3}));
        chk(n_rf1 == 18'h00155, "R4 leading bits ignored", 32'(n_rf1), 32'h155);

        // R3: activity while disabled, then an empty enable pulse
        ser_dat = 1'b1;
        for (int i = 0; i < 10; i++) begin
            ser_clk = 1'b1; tick(4);
            ser_clk = 1'b0; tick(4);
        end
        ser_dat = 1'b0;
        chk(n_rf1 == 18'h00155, "R3 idle activity no change", 32'(n_rf1), 32'h155);
        ser_en_n = 1'b0;
        tick(4);
        ser_en_n = 1'b1;
        saw = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (wr_stb[2]) saw = 1'b1;
        end
        chk(saw, "R3 empty pulse re-commits held word", 32'(saw), 32'h1);

        // R8 reserved addresses
        wr(4'd1, 18'h3FFFF);
        wr(4'd9, 18'h15555);
        wr(4'd15, 18'h2AAAA);
        chk(cfg_word == 18'h03028 && {if_on, rf_on} == 2'b10, "R8 cfg/enables kept",
            32'({cfg_word, if_on, rf_on}), 32'({18'h03028, 2'b10}));
        chk(n_rf1 == 18'h155 && n_rf2 == 17'h1FFFF && n_if == 16'h1234, "R8 dividers kept",
            32'(n_if), 32'h1234);

        // R11 writes land with everything powered down
        wr(4'd2, 18'h0);
        wr(4'd0, 18'h0);
        wr(4'd4, 18'h00ABC);
        chk(n_rf2 == 17'h00ABC, "R11 write while powered down", 32'(n_rf2), 32'hABC);
        wr(4'd2, 18'h3);
        chk(if_on && rf_on, "R11 enables both", 32'({if_on, rf_on}), 32'h3);

        // R1 mixed frames, model compared each cycle
        for (int k = 0; k < 24; k++) begin
            wr(alist[$urandom_range(0, 6)], 18'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 200000, 0);
            summary();
            $finish;
        end
    end
endmodule